// File: doc/BRIEF.md
# Two-Bank Routable Interrupt Controller

This block gathers thirty-two level-sensitive interrupt sources, split into two banks of sixteen, and turns them into five interrupt request lines for a processor. Each bank has an enable mask. A source is active only while its input level is high and its mask bit is set. Each request line is the OR of every active source, in either bank, that is routed to it.

Some pins in each bank can be routed. Each of these pins has a 3-bit line number held in one of four packed routing registers. The routable pins form an irregular set. Every other pin always drives line 0. Software uses a 16-bit register port with two windows. Window 0 holds the first bank's live levels, that bank's mask and all four routing registers. Window 1 holds the second bank's live levels and its mask. Writes take effect at the clock edge. A read strobe captures the addressed register into the read-data output at the same edge.

Top module: `route_icu`

## Requirements
- R1: After reset both masks read 0x0000, all request lines are low, and the routing registers read 0x0040, 0x0000, 0x0002, 0x0000 (offsets 0x04, 0x06, 0x1C, 0x1E). This places first-bank pin 2 on line 1, second-bank pin 0 on line 2 and every other pin on line 0.
- R2: Offset 0x00 reads the live source levels of the first bank in window 0 and of the second bank in window 1. Writes to that offset change nothing.
- R3: The first-bank mask is at window 0 offset 0x0C. The second-bank mask is at window 1 offset 0x06. Both are read/write. A source drives its line only when its level and its mask bit are both 1.
- R4: The routing fields are 3 bits wide. At window 0 offset 0x04, bits 0, 3, 6, 9 and 12 route first-bank pins 0, 1, 2, 3 and 8. At offset 0x06, bits 0, 6 and 9 route first-bank pins 9, 11 and 12. At offset 0x1C, bits 0, 3, 6, 9 and 12 route second-bank pins 0, 1, 3, 4 and 5. At offset 0x1E, the same bit positions route second-bank pins 6 to 10.
- R5: Pins that have no routing field always drive line 0.
- R6: A written routing code above 4 is stored, read back and used as 0.
- R7: Routing-register bits that belong to no field (bit 15 everywhere, and bits 3-5 and 12-14 at offset 0x06) read 0 and ignore writes.
- R8: Request line k is the OR, across both banks, of all active sources whose routing code equals k. Several lines can be high at the same time.
- R9: A request line changes exactly one clock edge after the source, mask or routing change that causes it.
- R10: Read data is captured at the edge where the read strobe is high. Offsets that map to no register read 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_a | input | 16 | First-bank source levels |
| src_b | input | 16 | Second-bank source levels |
| bus_win | input | 1 | Register window select (0 or 1) |
| bus_off | input | 5 | Byte offset within the window |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, registered |
| irq_out | output | 5 | Request lines 0 to 4, registered |

## Verification
The assertions assume three things about the inputs. Source levels and bus signals are stable around the clock edge. A write and a read are not issued in the same cycle to the same register. The offset is always one of the even offsets listed above or an unmapped one. The bench changes every input only on the falling clock edge. It raises exactly one strobe at a time, so a read never overlaps a write. It sweeps a single active source across all thirty-two pins for the default routing, for each of the five legal codes, and for illegal codes.

// File: rtl/route_icu.sv
module route_icu #(
  parameter int NLINE = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [15:0]      src_a,
  input  logic [15:0]      src_b,
  input  logic             bus_win,
  input  logic [4:0]       bus_off,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [15:0]      bus_wdata,
  output logic [15:0]      bus_rdata,
  output logic [NLINE-1:0] irq_out
);
  localparam logic [4:0]  OFF_PEND = 5'h00;
  localparam logic [4:0]  OFF_ASG0 = 5'h04;
  localparam logic [4:0]  OFF_ASG1 = 5'h06;
  localparam logic [4:0]  OFF_MSKA = 5'h0C;
  localparam logic [4:0]  OFF_ASG2 = 5'h1C;
  localparam logic [4:0]  OFF_ASG3 = 5'h1E;
  localparam logic [4:0]  OFF_MSKB = 5'h06;
  localparam logic [4:0]  FV_FULL  = 5'b11111;
  localparam logic [4:0]  FV_ASG1  = 5'b01101;
  localparam logic [15:0] DEF_ASG0 = 16'h0040;
  localparam logic [15:0] DEF_ASG2 = 16'h0002;

  logic [15:0] mask_a, mask_b;
  logic [15:0] asg0, asg1, asg2, asg3;
  logic [15:0] act_a, act_b;
  logic [2:0]  code_a [16];
  logic [2:0]  code_b [16];
  logic [NLINE-1:0] irq_nxt;
  logic [15:0] rd_mux;

  function automatic logic [15:0] clean(input logic [15:0] d, input logic [4:0] fv);
    logic [15:0] r;
    r = '0;
    for (int k = 0; k < 5; k++)
      if (fv[k] && d[3*k +: 3] <= 3'd4) r[3*k +: 3] = d[3*k +: 3];
    return r;
  endfunction

  assign act_a = src_a & mask_a;
  assign act_b = src_b & mask_b;

  always_comb begin
    for (int i = 0; i < 16; i++) begin
      code_a[i] = 3'd0;
      code_b[i] = 3'd0;
    end
    code_a[0]  = asg0[2:0];
    code_a[1]  = asg0[5:3];
    code_a[2]  = asg0[8:6];
    code_a[3]  = asg0[11:9];
    code_a[8]  = asg0[14:12];
    code_a[9]  = asg1[2:0];
    code_a[11] = asg1[8:6];
    code_a[12] = asg1[11:9];
    code_b[0]  = asg2[2:0];
    code_b[1]  = asg2[5:3];
    code_b[3]  = asg2[8:6];
    code_b[4]  = asg2[11:9];
    code_b[5]  = asg2[14:12];
    for (int k = 0; k < 5; k++) code_b[6+k] = asg3[3*k +: 3];
  end

  always_comb begin
    irq_nxt = '0;
    for (int j = 0; j < NLINE; j++)
      for (int i = 0; i < 16; i++)
        if ((act_a[i] && code_a[i] == 3'(j)) || (act_b[i] && code_b[i] == 3'(j)))
          irq_nxt[j] = 1'b1;
  end

  always_comb begin
    rd_mux = '0;
    if (!bus_win) begin
      case (bus_off)
        OFF_PEND: rd_mux = src_a;
        OFF_ASG0: rd_mux = asg0;
        OFF_ASG1: rd_mux = asg1;
        OFF_MSKA: rd_mux = mask_a;
        OFF_ASG2: rd_mux = asg2;
        OFF_ASG3: rd_mux = asg3;
        default:  rd_mux = '0;
      endcase
    end else begin
      case (bus_off)
        OFF_PEND: rd_mux = src_b;
        OFF_MSKB: rd_mux = mask_b;
        default:  rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_a    <= '0;
      mask_b    <= '0;
      asg0      <= DEF_ASG0;
      asg1      <= '0;
      asg2      <= DEF_ASG2;
      asg3      <= '0;
      irq_out   <= '0;
      bus_rdata <= '0;
    end else begin
      if (bus_wr) begin
        if (!bus_win) begin
          case (bus_off)
            OFF_MSKA: mask_a <= bus_wdata;
            OFF_ASG0: asg0   <= clean(bus_wdata, FV_FULL);
            OFF_ASG1: asg1   <= clean(bus_wdata, FV_ASG1);
            OFF_ASG2: asg2   <= clean(bus_wdata, FV_FULL);
            OFF_ASG3: asg3   <= clean(bus_wdata, FV_FULL);
            default: ;
          endcase
        end else if (bus_off == OFF_MSKB) begin
          mask_b <= bus_wdata;
        end
      end
      if (bus_rd) bus_rdata <= rd_mux;
      irq_out <= irq_nxt;
    end
  end
endmodule

module route_icu_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] src_a,
  input logic [15:0] src_b,
  input logic        bus_win,
  input logic [4:0]  bus_off,
  input logic        bus_wr,
  input logic        bus_rd,
  input logic [15:0] bus_wdata,
  input logic [15:0] bus_rdata,
  input logic [4:0]  irq_out,
  input logic [15:0] mask_a,
  input logic [15:0] mask_b,
  input logic [15:0] asg0,
  input logic [15:0] asg1,
  input logic [15:0] asg2,
  input logic [15:0] asg3
);
  function automatic logic fields_ok(input logic [15:0] r);
    logic ok;
    ok = !r[15];
    for (int k = 0; k < 5; k++) if (r[3*k +: 3] > 3'd4) ok = 1'b0;
    return ok;
  endfunction

  // R8
  irq_needs_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out != 5'd0 |-> $past(((src_a & mask_a) | (src_b & mask_b)) != 16'd0));

  // R5
  fixed_pin_line0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_a[5] && mask_a[5]) |=> irq_out[0]);

  // R2
  pend_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_win && bus_off == 5'h00) |=> bus_rdata == $past(src_a));

  // R3
  mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_win && bus_off == 5'h0C) |=> mask_a == $past(bus_wdata));

  // R6
  codes_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fields_ok(asg0) && fields_ok(asg1) && fields_ok(asg2) && fields_ok(asg3));

  // R7
  asg1_holes_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    asg1[5:3] == 3'd0 && asg1[15:12] == 4'd0);
endmodule

bind route_icu route_icu_chk u_chk (.*);

// File: tb/route_icu_bench.sv
`timescale 1ns/1ps
module route_icu_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] src_a = '0, src_b = '0;
  logic        bus_win = 1'b0;
  logic [4:0]  bus_off = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [4:0]  irq_out;

  int total = 0, bad = 0;
  bit done = 1'b0;
  logic [2:0] ca [16];
  logic [2:0] cb [16];
  localparam logic [15:0] ROUT_A = 16'h1B0F;
  localparam logic [15:0] ROUT_B = 16'h07FB;

  always #2 clk = ~clk;

  route_icu u_route_icu (.*);

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic w, input logic [4:0] o, input logic [15:0] d);
    @(negedge clk);
    bus_win = w; bus_off = o; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input string tag, input logic w, input logic [4:0] o, input logic [15:0] exp);
    @(negedge clk);
    bus_win = w; bus_off = o; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic settle_irq(input string tag, input logic [4:0] exp);
    @(negedge clk);
    @(negedge clk);
    chk(tag, {11'd0, irq_out}, {11'd0, exp});
  endtask

  task automatic codes_default();
    for (int i = 0; i < 16; i++) begin ca[i] = 3'd0; cb[i] = 3'd0; end
    ca[2] = 3'd1; cb[0] = 3'd2;
  endtask

  task automatic codes_uniform(input logic [2:0] c);
    for (int i = 0; i < 16; i++) begin
      ca[i] = ROUT_A[i] ? c : 3'd0;
      cb[i] = ROUT_B[i] ? c : 3'd0;
    end
  endtask

  task automatic sweep(input string tag);
    for (int b = 0; b < 2; b++)
      for (int p = 0; p < 16; p++) begin
        @(negedge clk);
        src_a = (b == 0) ? 16'(1 << p) : 16'd0;
        src_b = (b == 1) ? 16'(1 << p) : 16'd0;
        @(negedge clk);
        chk(tag, {11'd0, irq_out}, 16'(1 << ((b == 0) ? ca[p] : cb[p])));
      end
  endtask

  initial begin
    #400000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 irq", {11'd0, irq_out}, 16'd0);
    rd("R1 mask_a", 1'b0, 5'h0C, 16'h0000);
    rd("R1 mask_b", 1'b1, 5'h06, 16'h0000);
    rd("R1 asg0", 1'b0, 5'h04, 16'h0040);
    rd("R1 asg1", 1'b0, 5'h06, 16'h0000);
    rd("R1 asg2", 1'b0, 5'h1C, 16'h0002);
    rd("R1 asg3", 1'b0, 5'h1E, 16'h0000);
    // R3 masked sources stay silent
    src_a = 16'hFFFF; src_b = 16'hFFFF;
    settle_irq("R3 all masked", 5'h00);
    // R2 live levels, writes ignored
    src_a = 16'hA5A5; src_b = 16'h3C3C;
    rd("R2 pend a", 1'b0, 5'h00, 16'hA5A5);
    rd("R2 pend b", 1'b1, 5'h00, 16'h3C3C);
    src_a = 16'h1234;
    rd("R2 pend a live", 1'b0, 5'h00, 16'h1234);
    wr(1'b0, 5'h00, 16'h0000);
    wr(1'b1, 5'h00, 16'hFFFF);
    rd("R2 pend a after write", 1'b0, 5'h00, 16'h1234);
    rd("R2 pend b after write", 1'b1, 5'h00, 16'h3C3C);
    rd("R2 mask a untouched", 1'b0, 5'h0C, 16'h0000);
    rd("R2 mask b untouched", 1'b1, 5'h06, 16'h0000);
    // R10 unmapped offsets
    rd("R10 unmapped w0", 1'b0, 5'h02, 16'h0000);
    rd("R10 unmapped w1", 1'b1, 5'h0C, 16'h0000);
    // R3 partial masks
    src_a = 16'hFFFF; src_b = 16'hFFFF;
    wr(1'b0, 5'h0C, 16'h0004);
    settle_irq("R3 mask a pin2", 5'h02);
    wr(1'b1, 5'h06, 16'h0001);
    settle_irq("R3 mask b pin0", 5'h06);
    rd("R3 mask a read", 1'b0, 5'h0C, 16'h0004);
    rd("R3 mask b read", 1'b1, 5'h06, 16'h0001);
    // R5 default routing sweep
    wr(1'b0, 5'h0C, 16'hFFFF);
    wr(1'b1, 5'h06, 16'hFFFF);
    codes_default();
    sweep("R5 default routing");
    // R4 each legal code on every routable pin
    for (int c = 0; c < 5; c++) begin
      wr(1'b0, 5'h04, 16'(c * 16'h1249));
      wr(1'b0, 5'h06, 16'(c * 16'h1249));
      wr(1'b0, 5'h1C, 16'(c * 16'h1249));
      wr(1'b0, 5'h1E, 16'(c * 16'h1249));
      rd("R4 asg0 read", 1'b0, 5'h04, 16'(c * 16'h1249));
      rd("R7 asg1 read", 1'b0, 5'h06, 16'(c * 16'h0241));
      rd("R4 asg3 read", 1'b0, 5'h1E, 16'(c * 16'h1249));
      codes_uniform(3'(c));
      sweep("R4 routed sweep");
    end
    // R6 illegal codes
    wr(1'b0, 5'h04, 16'h7FFF);
    wr(1'b0, 5'h06, 16'h5B6D);
    wr(1'b0, 5'h1C, 16'h7FFF);
    wr(1'b0, 5'h1E, 16'h5B6D);
    rd("R6 asg0 read", 1'b0, 5'h04, 16'h0000);
    rd("R6 asg1 read", 1'b0, 5'h06, 16'h0000);
    rd("R6 asg2 read", 1'b0, 5'h1C, 16'h0000);
    rd("R6 asg3 read", 1'b0, 5'h1E, 16'h0000);
    codes_uniform(3'd0);
    sweep("R6 illegal as 0");
    // R7 holes
    wr(1'b0, 5'h06, 16'hC924);
    rd("R7 asg1 holes", 1'b0, 5'h06, 16'h0904);
    wr(1'b0, 5'h04, 16'hC924);
    rd("R7 asg0 bit15", 1'b0, 5'h04, 16'h4924);
    // R8 OR across banks
    wr(1'b0, 5'h04, 16'h0003);
    wr(1'b0, 5'h06, 16'h0000);
    wr(1'b0, 5'h1C, 16'h0003);
    wr(1'b0, 5'h1E, 16'h0004);
    src_a = 16'h0001; src_b = 16'h0001;
    settle_irq("R8 both banks line3", 5'h08);
    src_a = 16'h0021;
    settle_irq("R8 lines 0 and 3", 5'h09);
    src_a = 16'h0020;
    settle_irq("R8 bank b keeps line3", 5'h09);
    src_a = 16'h0001; src_b = 16'h0040;
    settle_irq("R8 lines 3 and 4", 5'h18);
    // R9 one-edge latency
    src_a = 16'h0000; src_b = 16'h0000;
    settle_irq("R9 idle", 5'h00);
    src_a = 16'h0001;
    #1 chk("R9 before edge", {11'd0, irq_out}, 16'h0000);
    @(negedge clk);
    chk("R9 after edge", {11'd0, irq_out}, 16'h0008);
    src_a = 16'h0000;
    #1 chk("R9 hold before edge", {11'd0, irq_out}, 16'h0008);
    @(negedge clk);
    chk("R9 clear after edge", {11'd0, irq_out}, 16'h0000);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule